// File: doc/BRIEF.md
# Segmented FIR Coefficient Store with Sequential Loader

This block keeps the complex coefficient set of a long partially parallel FIR filter. A host fills a staging buffer of in-phase/quadrature coefficient pairs through a write port at any time, without disturbing the filter. When the host issues an update command, a sequencer copies the staging buffer into a bank of segment RAMs. The copy moves one coefficient per clock cycle.

The filter datapath reads the segment RAMs in parallel. A shared phase index selects one local address, and every segment returns its coefficient at that address in the same cycle. One cycle of a time-division multiplexed multiply-accumulate therefore receives one tap from each segment. A busy flag marks the copy window. While the copy runs, host writes are admitted only to words the sequencer has already copied.

With the default parameters there are 128 taps in 8 segments of 16 words each, and each component is 16 bits wide. The sequencer has two states. IDLE waits for an update command. LOAD copies one word per cycle. The transitions are IDLE to LOAD on an update command, LOAD to LOAD while the copy index is below the last tap, and LOAD to IDLE after the last tap has been written.

Top module: `coef_loader`

## Requirements
- R1: After reset, `busy` is 0, `wr_ready` is 1, and every segment read returns 0 for both components.
- R2: A host write (`wr_en` with `wr_ready`) stores the pair at `wr_addr` in the staging buffer only. The segment read data does not change until a later update copies that word.
- R3: An update command sampled while `busy` is 0 makes `busy` 1 from the next cycle, and `busy` stays 1 for exactly 128 cycles (NSEG*SEG_DEPTH).
- R4: Staging word k is copied to segment k/16 at local address k mod 16. Segment s drives bits [16*s+15:16*s] of `rd_re` and `rd_im`.
- R5: Read data is registered. A phase index applied before a clock edge appears on `rd_re`/`rd_im` after that edge and not before.
- R6: Update commands that arrive while `busy` is 1 are ignored. They neither restart nor extend the copy.
- R7: While `busy` is 1, `wr_ready` is 1 only for addresses the sequencer has already copied. A write to any other address is held off and leaves the staging buffer unchanged. While `busy` is 0, `wr_ready` is 1.
- R8: When the copy finishes, the segments hold the staging contents as they stood when each word was copied. A word rewritten after it was copied reaches the segments only through a later update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the staging buffer |
| wr_addr | input | 7 | Staging buffer tap index |
| wr_re | input | 16 | In-phase part of the written coefficient |
| wr_im | input | 16 | Quadrature part of the written coefficient |
| wr_ready | output | 1 | Write at `wr_addr` is accepted this cycle |
| upd_req | input | 1 | Start copying staging buffer into the segments |
| busy | output | 1 | Copy in progress |
| rd_phase | input | 4 | Shared local address for the parallel read |
| rd_re | output | 128 | In-phase coefficients, one 16-bit lane per segment |
| rd_im | output | 128 | Quadrature coefficients, one 16-bit lane per segment |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a copy. It must hit an already-copied address, which is admitted, or a not-yet-copied address, which is held off. The bench starts an update, counts cycles on `busy` so that it knows the copy index, and in a chosen cycle drives writes on both sides of that index together with a redundant update command. A second update then shows which writes reached the buffer and how long each copy lasted.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_t;

endpackage

// File: rtl/coef_buffer.sv
module coef_buffer #(
    parameter int NTAP = 128,
    parameter int CW   = 16,
    localparam int AW  = $clog2(NTAP)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wre,
    input  logic [CW-1:0] wim,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rre,
    output logic [CW-1:0] rim
);

    logic [CW-1:0] mem_re [NTAP];
    logic [CW-1:0] mem_im [NTAP];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_re[waddr] <= wre;
            mem_im[waddr] <= wim;
        end
    end

    // Read is asynchronous, so a word and its copy slot line up in the same cycle.
    always_comb begin
        rre = mem_re[raddr];
        rim = mem_im[raddr];
    end

endmodule

// File: rtl/coef_load_seq.sv
module coef_load_seq
    import coef_ld_pkg::*;
#(
    parameter int NTAP = 128,
    localparam int AW  = $clog2(NTAP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_req,
    input  logic [AW-1:0] host_addr,
    output logic          host_ok,
    output logic          busy,
    output logic          copy_we,
    output logic [AW-1:0] copy_idx
);

    localparam logic [AW-1:0] LAST = AW'(NTAP - 1);

    ld_state_t     state, state_nx;
    logic [AW-1:0] idx, idx_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // Next state and index
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                idx_nx = '0;
                if (upd_req) state_nx = ST_LOAD;
            end
            ST_LOAD: begin
                if (idx == LAST) begin
                    state_nx = ST_IDLE;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx + 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        copy_we  = 1'b0;
        host_ok  = 1'b1;
        copy_idx = idx;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                host_ok = 1'b1;
            end
            ST_LOAD: begin
                busy    = 1'b1;
                copy_we = 1'b1;
                host_ok = (host_addr < idx);
            end
            default: begin
                busy    = 1'b0;
                host_ok = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/coef_seg_bank.sv
module coef_seg_bank #(
    parameter int NSEG      = 8,
    parameter int SEG_DEPTH = 16,
    parameter int CW        = 16,
    localparam int NTAP     = NSEG * SEG_DEPTH,
    localparam int AW       = $clog2(NTAP),
    localparam int PW       = $clog2(SEG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      widx,
    input  logic [CW-1:0]      wre,
    input  logic [CW-1:0]      wim,
    input  logic [PW-1:0]      phase,
    output logic [NSEG*CW-1:0] qre,
    output logic [NSEG*CW-1:0] qim
);

    // Upper index bits pick the segment, lower bits the local word.
    logic [PW-1:0] wloc;
    assign wloc = widx[PW-1:0];

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [CW-1:0] m_re [SEG_DEPTH];
        logic [CW-1:0] m_im [SEG_DEPTH];
        logic          sel;

        assign sel = we && (int'(widx) / SEG_DEPTH == s);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < SEG_DEPTH; w++) begin
                    m_re[w] <= '0;
                    m_im[w] <= '0;
                end
            end else if (sel) begin
                m_re[wloc] <= wre;
                m_im[wloc] <= wim;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                qre[s*CW +: CW] <= '0;
                qim[s*CW +: CW] <= '0;
            end else begin
                qre[s*CW +: CW] <= m_re[phase];
                qim[s*CW +: CW] <= m_im[phase];
            end
        end
    end

endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
    parameter int NSEG      = 8,
    parameter int SEG_DEPTH = 16,
    parameter int CW        = 16,
    localparam int NTAP     = NSEG * SEG_DEPTH,
    localparam int AW       = $clog2(NTAP),
    localparam int PW       = $clog2(SEG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CW-1:0]      wr_re,
    input  logic [CW-1:0]      wr_im,
    output logic               wr_ready,
    input  logic               upd_req,
    output logic               busy,
    input  logic [PW-1:0]      rd_phase,
    output logic [NSEG*CW-1:0] rd_re,
    output logic [NSEG*CW-1:0] rd_im
);

    logic          copy_we;
    logic [AW-1:0] copy_idx;
    logic [CW-1:0] stg_re, stg_im;

    coef_load_seq #(.NTAP(NTAP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_req  (upd_req),
        .host_addr(wr_addr),
        .host_ok  (wr_ready),
        .busy     (busy),
        .copy_we  (copy_we),
        .copy_idx (copy_idx)
    );

    coef_buffer #(.NTAP(NTAP), .CW(CW)) u_buf (
        .clk  (clk),
        .we   (wr_en && wr_ready),
        .waddr(wr_addr),
        .wre  (wr_re),
        .wim  (wr_im),
        .raddr(copy_idx),
        .rre  (stg_re),
        .rim  (stg_im)
    );

    coef_seg_bank #(.NSEG(NSEG), .SEG_DEPTH(SEG_DEPTH), .CW(CW)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (copy_we),
        .widx (copy_idx),
        .wre  (stg_re),
        .wim  (stg_im),
        .phase(rd_phase),
        .qre  (rd_re),
        .qim  (rd_im)
    );

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int NSEG      = 8,
    parameter int SEG_DEPTH = 16,
    parameter int CW        = 16,
    localparam int NTAP     = NSEG * SEG_DEPTH,
    localparam int PW       = $clog2(SEG_DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_req,
    input logic               busy,
    input logic               wr_ready,
    input logic [PW-1:0]      rd_phase,
    input logic [NSEG*CW-1:0] rd_re
);

    int unsigned run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run <= 0;
        else                 run <= run + 1;
    end

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_req) |=> busy);

    p_len_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run == NTAP - 1) |=> !busy);

    // Redundant commands inside the window must not cut or stretch it.
    p_len_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run < NTAP - 1) |=> busy);

    p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> wr_ready);

    p_rd_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && $stable(rd_phase)) |=> $stable(rd_re));

endmodule

bind coef_loader coef_loader_chk #(.NSEG(NSEG), .SEG_DEPTH(SEG_DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_req (upd_req),
    .busy    (busy),
    .wr_ready(wr_ready),
    .rd_phase(rd_phase),
    .rd_re   (rd_re)
);

// File: tb/test_coef_loader.sv
module test_coef_loader;

    localparam int NSEG = 8;
    localparam int SD   = 16;
    localparam int CW   = 16;
    localparam int NTAP = NSEG * SD;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [6:0]          wr_addr = '0;
    logic [CW-1:0]       wr_re = '0, wr_im = '0;
    logic                wr_ready;
    logic                upd_req = 1'b0;
    logic                busy;
    logic [3:0]          rd_phase = '0;
    logic [NSEG*CW-1:0]  rd_re, rd_im;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    coef_loader i_coef_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_re(wr_re), .wr_im(wr_im), .wr_ready(wr_ready), .upd_req(upd_req),
        .busy(busy), .rd_phase(rd_phase), .rd_re(rd_re), .rd_im(rd_im)
    );

    // phase, segment, expected in-phase value for tap seg*16+phase (3k+1)
    typedef struct packed { logic [3:0] ph; logic [2:0] sg; logic [15:0] ex; } vec_t;
    localparam vec_t VECS [8] = '{
        '{4'd0,  3'd0, 16'd1},   '{4'd5,  3'd2, 16'd112},
        '{4'd15, 3'd7, 16'd382}, '{4'd3,  3'd1, 16'd58},
        '{4'd10, 3'd4, 16'd223}, '{4'd7,  3'd6, 16'd310},
        '{4'd12, 3'd3, 16'd181}, '{4'd1,  3'd5, 16'd244}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane(input logic [NSEG*CW-1:0] v, input int s);
        return v[s*CW +: CW];
    endfunction

    task automatic read_at(input logic [3:0] ph);
        @(negedge clk);
        rd_phase = ph;
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int bcount;
        int allok;
        int n2;

        // Reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 rd_re zero", (rd_re == '0) ? 1 : 0, 1);
        chk("R1 rd_im zero", (rd_im == '0) ? 1 : 0, 1);

        // Fill staging buffer: re = 3k+1, im = 0x8000+k
        for (int k = 0; k < NTAP; k++) begin
            wr_en = 1'b1; wr_addr = 7'(k);
            wr_re = 16'(3*k + 1); wr_im = 16'(16'h8000 + k);
            @(negedge clk);
        end
        wr_en = 1'b0;
        read_at(4'd9);
        chk("R2 segments untouched re", (rd_re == '0) ? 1 : 0, 1);
        chk("R2 segments untouched im", (rd_im == '0) ? 1 : 0, 1);

        // Update with mid-copy stimulus
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        chk("R3 busy after update", busy, 1);
        bcount = 0;
        while (busy && bcount < 1000) begin
            if (bcount == 20) begin
                upd_req = 1'b1;                       // R6 redundant command
                wr_en = 1'b1; wr_addr = 7'd0;
                wr_re = 16'h7777; wr_im = 16'h1234;
                #1 chk("R7 ready behind copy index", wr_ready, 1);
            end else if (bcount == 21) begin
                upd_req = 1'b0;
                wr_en = 1'b1; wr_addr = 7'd100;
                wr_re = 16'hDEAD; wr_im = 16'hBEEF;
                #1 chk("R7 held ahead of copy index", wr_ready, 0);
            end else begin
                wr_en = 1'b0;
            end
            bcount++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R3 R6 busy length", bcount, NTAP);

        // Table walk: R4 mapping
        foreach (VECS[i]) begin
            read_at(VECS[i].ph);
            chk("R4 table lane", lane(rd_re, VECS[i].sg), VECS[i].ex);
        end

        // Full sweep R4
        allok = 1;
        for (int p = 0; p < SD; p++) begin
            read_at(4'(p));
            for (int s = 0; s < NSEG; s++) begin
                if (lane(rd_re, s) !== 16'(3*(s*SD+p)+1) && !(s == 0 && p == 0)) allok = 0;
                if (lane(rd_im, s) !== 16'(16'h8000 + s*SD+p) && !(s == 0 && p == 0)) allok = 0;
            end
        end
        chk("R4 full sweep", allok, 1);

        // R8: word 0 rewritten after copy stays old in segments
        read_at(4'd0);
        chk("R8 late write not copied", lane(rd_re, 0), 16'd1);

        // R5 latency
        @(negedge clk);
        rd_phase = 4'd2;
        #1 chk("R5 no change before edge", lane(rd_re, 0), 16'd1);
        @(negedge clk);
        chk("R5 value after edge", lane(rd_re, 0), 16'd7);

        // Second update
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        wait_idle(n2);
        chk("R3 second busy length", n2, NTAP);
        read_at(4'd0);
        chk("R2 accepted write copied re", lane(rd_re, 0), 16'h7777);
        chk("R2 accepted write copied im", lane(rd_im, 0), 16'h1234);
        read_at(4'd4);
        chk("R7 held write not stored", lane(rd_re, 6), 16'd301);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule